// File: doc/BRIEF.md
# Short-Command Serial Flash Engine

This block is a small register-mapped SPI master for the short commands a host issues to a serial flash device, such as an identification read, a status read or a write-enable. The host fills byte registers with an opcode, up to three address bytes and one extra byte. It then writes a control byte that picks one of four outgoing length classes, the number of bytes to read back (0 to 3) and a start code. The engine selects the device, shifts the chosen bytes out MSB first in SPI mode 0, clocks in the response bytes and stores them in the register file. While it works, the top bit of the status register stays set.

The outgoing byte order depends on the length class. Address bytes are stored in reverse wire order: the byte sent first sits at the highest address offset. The extra byte shares its offset with the last response slot, so a read of three bytes overwrites it. The serial clock is the system clock divided by a parameter.

Top module: `sfe_top`

## Requirements
- R1: After reset every register offset 0 to 7 reads 0x00, chip select is high and the serial clock is low.
- R2: An accepted start sets status bit 7 (offset 0) to 1. Chip select is low only during a transfer. Status bit 7 returns to 0 after chip select has risen, and one frame carries exactly the write bytes plus the read bytes.
- R3: Length class 0 (control bits 1:0 = 0) sends only the opcode held at offset 1.
- R4: Length class 1 sends the opcode and then the byte at offset 7.
- R5: Length class 2 sends the opcode and then the bytes at offsets 4, 3 and 2, in that order.
- R6: Length class 3 sends the opcode, then offsets 4, 3 and 2, then the byte at offset 7.
- R7: Control bits 3:2 give N, the number of read bytes (0 to 3). N bytes with MOSI held at 0 follow the write bytes. The k-th byte received is stored at offset 5+k. Response offsets at or above 5+N keep their previous value.
- R8: SPI mode 0, MSB first: each serial clock high phase lasts HALF_DIV system clocks, and MOSI does not change while the serial clock is high.
- R9: A control write starts a transfer only when bits 7:4 equal 4'b0101. Any other value leaves the engine idle and chip select high.
- R10: A control write made while a transfer is in progress is ignored. The running frame keeps its length, and no second frame follows.
- R11: Offsets 1 to 7 read back the last byte written to them, or the last response byte captured into them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data for host_addr (combinational) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Device select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
Several properties are checked on every cycle: the shifter runs only while the device is selected, MOSI holds steady through each serial clock high phase, the frame length stays frozen during a transfer, and a control write with a wrong start code leaves the engine idle. The response capture index is also checked against the latched read count on every cycle. Other behaviours can only be shown by the bench scenarios, because they depend on whole byte streams and on register contents: the per-class byte order with the reversed address offsets, which response slots are overwritten and which are preserved, and the width of each clock high phase. The bench scoreboard compares every byte that appears on MOSI against the order predicted for each length class.

// File: rtl/sfe_pkg.sv
// Shared types and constants for the short-command serial flash engine.
// Assumes 8-bit bytes and a register window of eight offsets.
package sfe_pkg;
    localparam int BYTE_W  = 8;
    localparam int MAX_WR  = 5;
    localparam int MAX_RD  = 3;
    localparam int OFS_W   = 3;
    localparam int RX_BASE = 5;
    localparam int CNT_W   = $clog2(MAX_WR + MAX_RD + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    // Outgoing length class carried in control bits 1:0
    typedef enum logic [1:0] {
        WL_OP          = 2'd0,
        WL_OP_EXT      = 2'd1,
        WL_OP_ADDR     = 2'd2,
        WL_OP_ADDR_EXT = 2'd3
    } wlen_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_CLOSE = 2'd3
    } seq_e;

    // Number of bytes placed on the wire for a length class
    function automatic logic [CNT_W-1:0] wlen_bytes(wlen_e c);
        case (c)
            WL_OP:      return CNT_W'(1);
            WL_OP_EXT:  return CNT_W'(2);
            WL_OP_ADDR: return CNT_W'(4);
            default:    return CNT_W'(5);
        endcase
    endfunction
endpackage

// File: rtl/sfe_regs.sv
// Register file and control decode.
// Offset 0 reads the busy status, and a write to it may raise a start pulse.
// Offsets 1..7 hold bytes. The sequencer's capture port has priority over a
// host write to the same offset in the same cycle.
module sfe_regs
    import sfe_pkg::*;
#(
    parameter logic [2:0] START_CODE = 3'b101
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [OFS_W-1:0] host_addr,
    input  byte_t            host_wdata,
    output byte_t            host_rdata,
    input  logic             busy_i,
    input  logic             cap_we,
    input  logic [1:0]       cap_idx,
    input  byte_t            cap_data,
    output logic             start_o,
    output wlen_e            cls_o,
    output logic [1:0]       rcnt_o,
    output byte_t            op_o,
    output byte_t            adr_first_o,
    output byte_t            adr_mid_o,
    output byte_t            adr_last_o,
    output byte_t            ext_o
);
    localparam int NREG = (1 << OFS_W) - 1;

    byte_t regs_q [1:NREG];
    logic  ctrl_wr;

    assign ctrl_wr = host_we && (host_addr == '0);

    // Start is accepted only when idle and the upper nibble matches
    assign start_o = ctrl_wr && !busy_i && (host_wdata[7:4] == {1'b0, START_CODE});
    assign cls_o   = wlen_e'(host_wdata[1:0]);
    assign rcnt_o  = host_wdata[3:2];

    // Byte storage: a response capture wins over a host write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i <= NREG; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 1; i <= NREG; i++) begin
                if (cap_we && ((RX_BASE + int'(cap_idx)) == i))
                    regs_q[i] <= cap_data;
                else if (host_we && (host_addr == OFS_W'(i)))
                    regs_q[i] <= host_wdata;
            end
        end
    end

    // Read mux: status at offset 0, stored bytes elsewhere
    always_comb begin
        if (host_addr == '0) host_rdata = {busy_i, 7'b0};
        else                 host_rdata = regs_q[host_addr];
    end

    assign op_o        = regs_q[1];
    assign adr_first_o = regs_q[4];
    assign adr_mid_o   = regs_q[3];
    assign adr_last_o  = regs_q[2];
    assign ext_o       = regs_q[7];
endmodule

// File: rtl/sfe_shift.sv
// Byte shifter in SPI mode 0, MSB first.
// Assumes go_i arrives only while active_o is low. Each serial clock phase
// lasts HALF system clocks. MISO is sampled on the rising edge, and MOSI
// advances on the falling edge. done_o pulses for one cycle after the eighth
// falling edge, with the received byte on rx_o.
module sfe_shift
    import sfe_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  go_i,
    input  byte_t tx_i,
    output logic  done_o,
    output byte_t rx_o,
    output logic  active_o,
    output logic  sclk_o,
    output logic  mosi_o,
    input  logic  miso_i
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] div_q;
    logic [2:0]    bit_q;
    byte_t         sr_q, rx_q;
    logic          act_q, sclk_q, done_q;
    logic          tick;

    assign tick = (div_q == CW'(HALF - 1));

    // Divider, phase toggling and bit shifting for one byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            bit_q  <= '0;
            sr_q   <= '0;
            rx_q   <= '0;
            act_q  <= 1'b0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!act_q) begin
                div_q  <= '0;
                sclk_q <= 1'b0;
                if (go_i) begin
                    act_q <= 1'b1;
                    sr_q  <= tx_i;
                    bit_q <= '0;
                end
            end else if (tick) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[BYTE_W-2:0], miso_i};
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        act_q  <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        sr_q  <= {sr_q[BYTE_W-2:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + CW'(1);
            end
        end
    end

    assign done_o   = done_q;
    assign rx_o     = rx_q;
    assign active_o = act_q;
    assign sclk_o   = sclk_q;
    assign mosi_o   = sr_q[BYTE_W-1];

    // R8
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && $past(sclk_q)) |-> $stable(sr_q[BYTE_W-1]));
endmodule

// File: rtl/sfe_seq.sv
// Frame sequencer.
// On start it latches the byte list for the length class and the read count.
// It then hands bytes to the shifter one at a time: write bytes first, then
// zero bytes for the reads. Response bytes are routed to capture slots 0..2.
// Chip select stays low from the start until one cycle after the last byte.
module sfe_seq
    import sfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  wlen_e            cls_i,
    input  logic [1:0]       rcnt_i,
    input  byte_t            op_i,
    input  byte_t            adr_first_i,
    input  byte_t            adr_mid_i,
    input  byte_t            adr_last_i,
    input  byte_t            ext_i,
    output logic             go_o,
    output byte_t            tx_o,
    input  logic             done_i,
    input  byte_t            rx_i,
    output logic             cap_we_o,
    output logic [1:0]       cap_idx_o,
    output byte_t            cap_data_o,
    output logic             busy_o,
    output logic             cs_n_o
);
    seq_e             state_q;
    byte_t            lst_q  [0:MAX_WR-1];
    byte_t            nxt_lst[0:MAX_WR-1];
    logic [CNT_W-1:0] idx_q, nwr_q, total_q;
    logic [1:0]       rcnt_q;
    logic             in_write;

    // Wire order of the outgoing bytes for the requested class
    always_comb begin
        nxt_lst[0] = op_i;
        for (int k = 1; k < MAX_WR; k++) nxt_lst[k] = '0;
        case (cls_i)
            WL_OP_EXT: nxt_lst[1] = ext_i;
            WL_OP_ADDR: begin
                nxt_lst[1] = adr_first_i;
                nxt_lst[2] = adr_mid_i;
                nxt_lst[3] = adr_last_i;
            end
            WL_OP_ADDR_EXT: begin
                nxt_lst[1] = adr_first_i;
                nxt_lst[2] = adr_mid_i;
                nxt_lst[3] = adr_last_i;
                nxt_lst[4] = ext_i;
            end
            default: ;
        endcase
    end

    // Frame control: latch on start, step through bytes, release select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
            nwr_q   <= '0;
            total_q <= '0;
            rcnt_q  <= '0;
            for (int k = 0; k < MAX_WR; k++) lst_q[k] <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (start_i) begin
                    for (int k = 0; k < MAX_WR; k++) lst_q[k] <= nxt_lst[k];
                    nwr_q   <= wlen_bytes(cls_i);
                    total_q <= wlen_bytes(cls_i) + CNT_W'(rcnt_i);
                    rcnt_q  <= rcnt_i;
                    idx_q   <= '0;
                    state_q <= SQ_ISSUE;
                end
                SQ_ISSUE: state_q <= SQ_WAIT;
                SQ_WAIT: if (done_i) begin
                    if (idx_q == total_q - CNT_W'(1)) begin
                        state_q <= SQ_CLOSE;
                    end else begin
                        idx_q   <= idx_q + CNT_W'(1);
                        state_q <= SQ_ISSUE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign in_write   = (idx_q < nwr_q);
    assign go_o       = (state_q == SQ_ISSUE);
    assign tx_o       = in_write ? lst_q[idx_q[2:0]] : '0;
    assign cap_we_o   = (state_q == SQ_WAIT) && done_i && !in_write;
    assign cap_idx_o  = 2'(idx_q - nwr_q);
    assign cap_data_o = rx_i;
    assign busy_o     = (state_q != SQ_IDLE);
    assign cs_n_o     = (state_q == SQ_IDLE);

    // R10
    frame_len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SQ_IDLE && $past(state_q) != SQ_IDLE) |-> ($stable(total_q) && $stable(rcnt_q)));

    // R7
    cap_slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_we_o |-> (cap_idx_o < rcnt_q));
endmodule

// File: rtl/sfe_top.sv
// Short-command serial flash engine: register file, frame sequencer and byte
// shifter. Assumes a single device on one select line and HALF_DIV >= 1.
module sfe_top
    import sfe_pkg::*;
#(
    parameter int         HALF_DIV   = 2,
    parameter logic [2:0] START_CODE = 3'b101
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_we,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       spi_sclk,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    logic       busy, start, go, done, cap_we, sh_act;
    logic [1:0] rcnt, cap_idx;
    wlen_e      cls;
    byte_t      op_b, a_first, a_mid, a_last, ext_b, tx_b, rx_b, cap_b;

    sfe_regs #(.START_CODE(START_CODE)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .busy_i(busy),
        .cap_we(cap_we), .cap_idx(cap_idx), .cap_data(cap_b),
        .start_o(start), .cls_o(cls), .rcnt_o(rcnt),
        .op_o(op_b), .adr_first_o(a_first), .adr_mid_o(a_mid),
        .adr_last_o(a_last), .ext_o(ext_b)
    );

    sfe_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .cls_i(cls), .rcnt_i(rcnt),
        .op_i(op_b), .adr_first_i(a_first), .adr_mid_i(a_mid),
        .adr_last_i(a_last), .ext_i(ext_b),
        .go_o(go), .tx_o(tx_b), .done_i(done), .rx_i(rx_b),
        .cap_we_o(cap_we), .cap_idx_o(cap_idx), .cap_data_o(cap_b),
        .busy_o(busy), .cs_n_o(spi_cs_n)
    );

    sfe_shift #(.HALF(HALF_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .go_i(go), .tx_i(tx_b), .done_o(done), .rx_o(rx_b),
        .active_o(sh_act), .sclk_o(spi_sclk), .mosi_o(spi_mosi),
        .miso_i(spi_miso)
    );

    // R2
    shift_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_act |-> !spi_cs_n);

    // R9
    bad_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == 3'd0 && host_wdata[7:4] != {1'b0, START_CODE} && !busy)
        |=> !busy);
endmodule

// File: tb/sim_sfe_top.sv
// Scoreboard bench: the driver queues expected MOSI bytes, and a monitor
// pops them as bytes appear on the wire. A slave model drives MISO.
module sim_sfe_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       miso = 1'b0;
    wire  [7:0] rdata;
    wire        sclk, cs_n, mosi;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfe_top #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .host_we(we), .host_addr(addr),
        .host_wdata(wdata), .host_rdata(rdata), .spi_sclk(sclk),
        .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
    );

    int n_cmp = 0, n_bad = 0;
    logic [7:0] exp_q[$];
    logic [7:0] resp[8];
    logic [7:0] model[8];
    string cur_tag = "R1";
    int frames = 0, frame_bytes = 0, last_bytes = 0;
    int sbit = 0, mon_bits = 0, sclk_err = 0, hi_cnt = 0;
    logic [7:0] mon_sr = '0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Slave model: present the response bit stream MSB first
    always @(negedge cs_n) begin
        sbit = 0; miso = resp[0][7]; frames++; frame_bytes = 0; mon_bits = 0;
    end
    always @(negedge sclk) if (cs_n === 1'b0) begin
        sbit++;
        miso = resp[(sbit/8) % 8][7 - (sbit % 8)];
    end
    always @(posedge cs_n) last_bytes = frame_bytes;

    // Monitor: assemble MOSI bytes and compare against the scoreboard
    always @(posedge sclk) if (cs_n === 1'b0) begin
        mon_sr = {mon_sr[6:0], mosi};
        mon_bits++;
        if (mon_bits == 8) begin
            mon_bits = 0;
            frame_bytes++;
            if (exp_q.size() == 0) chk({cur_tag, " unexpected byte"}, mon_sr, 'h100);
            else chk({cur_tag, " mosi byte"}, mon_sr, exp_q.pop_front());
        end
    end

    // R8 phase-width and MOSI-hold observer, sampled between edges
    always @(negedge clk) begin
        if (sclk === 1'b1) begin
            hi_cnt++;
            if (prev_sclk && mosi !== prev_mosi) sclk_err++;
        end else if (prev_sclk) begin
            if (hi_cnt != HALF) sclk_err++;
            hi_cnt = 0;
        end
        prev_sclk = (sclk === 1'b1);
        prev_mosi = mosi;
    end

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1 we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; #1 v = rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        int guard = 0;
        do begin rd(3'd0, v); guard++; end while (v[7] && guard < 5000);
    endtask

    task automatic set_resp(logic [7:0] seed);
        for (int k = 0; k < 8; k++) resp[k] = seed + 8'(k * 8'h23) ^ 8'h5A;
    endtask

    task automatic check_regs(string tag);
        logic [7:0] v;
        for (int o = 1; o < 8; o++) begin rd(3'(o), v); chk({tag, " R11 readback"}, v, model[o]); end
    endtask

    task automatic xfer(string tag, logic [1:0] cls, logic [1:0] nrd, logic [7:0] op,
                        logic [7:0] a4, logic [7:0] a3, logic [7:0] a2, logic [7:0] x7);
        logic [7:0] v;
        int nw;
        wr(3'd1, op); wr(3'd4, a4); wr(3'd3, a3); wr(3'd2, a2); wr(3'd7, x7);
        model[1] = op; model[4] = a4; model[3] = a3; model[2] = a2; model[7] = x7;
        nw = (cls == 0) ? 1 : (cls == 1) ? 2 : (cls == 2) ? 4 : 5;
        exp_q.push_back(op);
        if (cls == 1) exp_q.push_back(x7);
        if (cls >= 2) begin exp_q.push_back(a4); exp_q.push_back(a3); exp_q.push_back(a2); end
        if (cls == 3) exp_q.push_back(x7);
        for (int j = 0; j < nrd; j++) exp_q.push_back(8'h00);
        cur_tag = tag;
        wr(3'd0, {4'b0101, nrd, cls});
        rd(3'd0, v); chk({tag, " R2 busy set"}, v[7], 1);
        chk({tag, " R2 select low"}, cs_n, 0);
        wait_idle();
        chk({tag, " R2 frame bytes"}, last_bytes, nw + nrd);
        chk({tag, " R2 select high"}, cs_n, 1);
        chk({tag, " scoreboard drained"}, exp_q.size(), 0);
        for (int j = 0; j < nrd; j++) model[5 + j] = resp[nw + j];
        check_regs({tag, " R7"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int f0;
        for (int k = 0; k < 8; k++) begin model[k] = '0; resp[k] = '0; end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, v); chk("R1 status", v, 0);
        chk("R1 cs_n", cs_n, 1);
        chk("R1 sclk", sclk, 0);
        check_regs("R1");

        set_resp(8'h10); xfer("R3 class0 read3", 2'd0, 2'd3, 8'h9F, 8'h00, 8'h00, 8'h00, 8'hEE);
        set_resp(8'h31); xfer("R4 class1 read0", 2'd1, 2'd0, 8'h01, 8'h00, 8'h00, 8'h00, 8'h7C);
        set_resp(8'h52); xfer("R5 class2 read2", 2'd2, 2'd2, 8'h03, 8'hA1, 8'hB2, 8'hC3, 8'hD4);
        set_resp(8'h73); xfer("R6 class3 read1", 2'd3, 2'd1, 8'h02, 8'h12, 8'h34, 8'h56, 8'h78);
        set_resp(8'h94); xfer("R6 class3 read3", 2'd3, 2'd3, 8'hAB, 8'h80, 8'h01, 8'hFF, 8'h5A);
        set_resp(8'hB5); xfer("R5 class2 read0", 2'd2, 2'd0, 8'h20, 8'h0F, 8'hF0, 8'h3C, 8'h66);

        // R9: wrong start field, and a set reserved bit, start nothing
        f0 = frames;
        wr(3'd0, 8'h3D); rd(3'd0, v); chk("R9 code 011 status", v, 0);
        wr(3'd0, 8'hD0); rd(3'd0, v); chk("R9 bit7 set status", v, 0);
        repeat (40) @(posedge clk);
        chk("R9 no frame", frames, f0);
        chk("R9 cs_n high", cs_n, 1);

        // R10: a control write during a frame is ignored
        set_resp(8'hC6);
        wr(3'd1, 8'h06); model[1] = 8'h06;
        exp_q.push_back(8'h06);
        cur_tag = "R10 ignore";
        f0 = frames;
        wr(3'd0, 8'h50);
        wr(3'd0, 8'h5F);
        rd(3'd0, v); chk("R10 still busy", v[7], 1);
        wait_idle();
        repeat (60) @(posedge clk);
        chk("R10 frame bytes", last_bytes, 1);
        chk("R10 single frame", frames, f0 + 1);
        chk("R10 scoreboard drained", exp_q.size(), 0);
        check_regs("R10 R7");

        chk("R8 phase width and mosi hold", sclk_err, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule